// File: doc/BRIEF.md
# Clock Output Gating and Test Controller

This block is the digital control stage behind the outputs of a desktop clock generator. It takes eight clock groups that are already running (reference, IOAPIC, USB, AGP, CPU, PCI, free-running PCI and SDRAM) and decides, group by group, whether each one reaches its output pin. Three active-low power-management pins drive that choice: a CPU halt, a PCI halt and a full sleep. A lock input can disable all three pins. Two configuration bits, supplied as plain inputs, override the pins. One puts every output into high impedance. The other replaces every output with the external test clock or a fixed division of it.

Each group has its own gate cell, clocked by that group's source clock. The cell synchronizes the run request and opens or closes the gate only while the source is low. An output therefore carries only whole high phases. A shared divider runs on the test clock and supplies the half- and quarter-rate test clocks. The divider restarts from zero each time test mode is entered. Output enables come out as a per-group vector beside the clock vector.

Group bit positions in `src_clk_i`, `clk_o` and `clk_oe_o`: 0 reference, 1 IOAPIC, 2 USB, 3 AGP, 4 CPU, 5 PCI, 6 free-running PCI, 7 SDRAM.

Top module: `ccg_clk_ctrl`

## Requirements
- R1: While `rst_ni` is low, every bit of `clk_o` is low.
- R2: While `pm_pin_lock_i` is high, the three halt and sleep pins have no effect: all eight groups toggle and `osc_pll_off_o` stays low.
- R3: With the lock low and `sleep_ni` low, all eight outputs stay low and `osc_pll_off_o` is high.
- R4: With the lock low, `sleep_ni` high and `cpu_halt_ni` low, the CPU output (bit 4) stays low and every other group keeps toggling.
- R5: With the lock low, `sleep_ni` high and `pci_halt_ni` low, the PCI output (bit 5) stays low while the free-running PCI output (bit 6) keeps toggling.
- R6: The AGP (bit 3), reference, IOAPIC, USB, SDRAM and free-running PCI groups ignore both halt pins, alone and together, and stop only on sleep.
- R7: A gated output is high only while its source clock is high, and every high pulse lasts a full source high phase. After a run request returns, the output toggles again within three source periods.
- R8: With `cfg_hiz_i` high, every bit of `clk_oe_o` is low, whatever the test bit or the pins; with it low, every bit is high.
- R9: With `cfg_test_i` high and `cfg_hiz_i` low, bits 0 and 1 carry the test clock, bits 2, 3, 4 and 7 carry it divided by 2, and bits 5 and 6 carry it divided by 4, whatever the pins.
- R10: On entry to test mode (default two synchronizer stages), the divided outputs are low for the first two test-clock rising edges. The half-rate output rises on the third edge and the quarter-rate output rises on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset for all gate cells and the divider |
| src_clk_i | input | 8 | Source clocks of the eight groups |
| ext_tck_i | input | 1 | External test clock |
| pm_pin_lock_i | input | 1 | High: halt and sleep pins are ignored |
| cpu_halt_ni | input | 1 | Active-low CPU group halt request |
| pci_halt_ni | input | 1 | Active-low PCI group halt request |
| sleep_ni | input | 1 | Active-low sleep request, stops every group |
| cfg_hiz_i | input | 1 | Configuration bit: all outputs high impedance |
| cfg_test_i | input | 1 | Configuration bit: outputs driven from the test clock |
| clk_o | output | 8 | Clock outputs per group |
| clk_oe_o | output | 8 | Output enables per group, high to drive |
| osc_pll_off_o | output | 1 | Request to shut the oscillator and PLLs down |

## Verification
The assertions assume that each group's source clock is a clean, free-running square wave. They also assume that the two configuration bits change only while the test clock is low and stay steady over many cycles. The halt and sleep pins may change at any moment, because only the synchronizers see them. The bench keeps to these assumptions: it runs every source as an independent fixed-period clock and writes the configuration bits only on the falling test-clock edge. It toggles the CPU halt pin at irregular offsets so that the gate cells see requests arriving in every phase of their clocks.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;

  localparam int CCG_N_GRP = 8;

  localparam int GRP_REF    = 0;
  localparam int GRP_IOAPIC = 1;
  localparam int GRP_USB    = 2;
  localparam int GRP_AGP    = 3;
  localparam int GRP_CPU    = 4;
  localparam int GRP_PCI    = 5;
  localparam int GRP_PCIF   = 6;
  localparam int GRP_SDRAM  = 7;

  typedef enum logic [1:0] {
    TAP_DIRECT  = 2'd0,
    TAP_HALF    = 2'd1,
    TAP_QUARTER = 2'd2
  } tap_e;

  // Group follows the CPU halt pin
  function automatic logic grp_obeys_cpu(input int grp);
    return (grp == GRP_CPU);
  endfunction

  // Group follows the PCI halt pin
  function automatic logic grp_obeys_pci(input int grp);
    return (grp == GRP_PCI);
  endfunction

  // Test-clock tap a group takes in test mode
  function automatic tap_e grp_test_tap(input int grp);
    tap_e t;
    case (grp)
      GRP_REF, GRP_IOAPIC: t = TAP_DIRECT;
      GRP_PCI, GRP_PCIF:   t = TAP_QUARTER;
      default:             t = TAP_HALF;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/ccg_halt_decode.sv
`timescale 1ns/1ps
module ccg_halt_decode
  import ccg_pkg::*;
(
  input  logic                 pin_lock_i,
  input  logic                 cpu_halt_ni,
  input  logic                 pci_halt_ni,
  input  logic                 sleep_ni,
  output logic [CCG_N_GRP-1:0] run_req_o,
  output logic                 sleep_req_o
);

  logic pins_live;
  logic cpu_req;
  logic pci_req;

  assign pins_live   = ~pin_lock_i;
  assign sleep_req_o = pins_live & ~sleep_ni;
  assign cpu_req     = pins_live & ~cpu_halt_ni;
  assign pci_req     = pins_live & ~pci_halt_ni;

  always_comb begin
    for (int g = 0; g < CCG_N_GRP; g++) begin
      run_req_o[g] = ~(sleep_req_o
                       | (grp_obeys_cpu(g) & cpu_req)
                       | (grp_obeys_pci(g) & pci_req));
    end
  end

endmodule

// File: rtl/ccg_gate_cell.sv
`timescale 1ns/1ps
module ccg_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_req_i,
  output logic run_sync_o,
  output logic en_o,
  output logic clk_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], run_req_i};
  end

  // Enable moves only on the falling edge, i.e. while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= sync_q[SYNC_STAGES-1];
  end

  assign run_sync_o = sync_q[SYNC_STAGES-1];
  assign en_o       = en_q;
  assign clk_o      = clk_i & en_q;

endmodule

// File: rtl/ccg_test_div.sv
`timescale 1ns/1ps
module ccg_test_div #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic             run_sync_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W:0]   taps_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DIV_W-1:0]       cnt_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], run_i};
      if (!sync_q[SYNC_STAGES-1]) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_sync_o = sync_q[SYNC_STAGES-1];
  assign cnt_o      = cnt_q;
  assign taps_o[0]  = tck_i;

  for (genvar k = 1; k <= DIV_W; k++) begin : g_tap
    assign taps_o[k] = cnt_q[k-1];
  end

endmodule

// File: rtl/ccg_out_sel.sv
`timescale 1ns/1ps
module ccg_out_sel
  import ccg_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic [CCG_N_GRP-1:0] gated_i,
  input  logic [DIV_W:0]       taps_i,
  input  logic                 test_i,
  input  logic                 hiz_i,
  output logic [CCG_N_GRP-1:0] clk_o,
  output logic [CCG_N_GRP-1:0] oe_o
);

  for (genvar g = 0; g < CCG_N_GRP; g++) begin : g_sel
    localparam int TAP_RAW = int'(grp_test_tap(g));
    localparam int TAP_IDX = (TAP_RAW > DIV_W) ? DIV_W : TAP_RAW;

    always_comb begin
      if (hiz_i) begin
        clk_o[g] = 1'b0;
        oe_o[g]  = 1'b0;
      end else if (test_i) begin
        clk_o[g] = taps_i[TAP_IDX];
        oe_o[g]  = 1'b1;
      end else begin
        clk_o[g] = gated_i[g];
        oe_o[g]  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ccg_clk_ctrl.sv
`timescale 1ns/1ps
module ccg_clk_ctrl
  import ccg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic                 rst_ni,
  input  logic [CCG_N_GRP-1:0] src_clk_i,
  input  logic                 ext_tck_i,
  input  logic                 pm_pin_lock_i,
  input  logic                 cpu_halt_ni,
  input  logic                 pci_halt_ni,
  input  logic                 sleep_ni,
  input  logic                 cfg_hiz_i,
  input  logic                 cfg_test_i,
  output logic [CCG_N_GRP-1:0] clk_o,
  output logic [CCG_N_GRP-1:0] clk_oe_o,
  output logic                 osc_pll_off_o
);

  logic [CCG_N_GRP-1:0] run_req;
  logic [CCG_N_GRP-1:0] run_sync;
  logic [CCG_N_GRP-1:0] gate_en;
  logic [CCG_N_GRP-1:0] gated;
  logic                 div_run;
  logic [DIV_W-1:0]     div_cnt;
  logic [DIV_W:0]       taps;

  ccg_halt_decode u_decode (
    .pin_lock_i  (pm_pin_lock_i),
    .cpu_halt_ni (cpu_halt_ni),
    .pci_halt_ni (pci_halt_ni),
    .sleep_ni    (sleep_ni),
    .run_req_o   (run_req),
    .sleep_req_o (osc_pll_off_o)
  );

  for (genvar g = 0; g < CCG_N_GRP; g++) begin : g_gate
    ccg_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_i      (src_clk_i[g]),
      .rst_ni     (rst_ni),
      .run_req_i  (run_req[g]),
      .run_sync_o (run_sync[g]),
      .en_o       (gate_en[g]),
      .clk_o      (gated[g])
    );
  end

  ccg_test_div #(.SYNC_STAGES(SYNC_STAGES), .DIV_W(DIV_W)) u_div (
    .tck_i      (ext_tck_i),
    .rst_ni     (rst_ni),
    .run_i      (cfg_test_i),
    .run_sync_o (div_run),
    .cnt_o      (div_cnt),
    .taps_o     (taps)
  );

  ccg_out_sel #(.DIV_W(DIV_W)) u_sel (
    .gated_i (gated),
    .taps_i  (taps),
    .test_i  (cfg_test_i),
    .hiz_i   (cfg_hiz_i),
    .clk_o   (clk_o),
    .oe_o    (clk_oe_o)
  );

endmodule

// File: rtl/ccg_clk_ctrl_chk.sv
`timescale 1ns/1ps
module ccg_clk_ctrl_chk
  import ccg_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input logic                 rst_ni,
  input logic [CCG_N_GRP-1:0] src_clk_i,
  input logic                 ext_tck_i,
  input logic                 cfg_hiz_i,
  input logic                 cfg_test_i,
  input logic [CCG_N_GRP-1:0] clk_o,
  input logic [CCG_N_GRP-1:0] clk_oe_o,
  input logic [CCG_N_GRP-1:0] gate_en,
  input logic [CCG_N_GRP-1:0] run_sync,
  input logic                 div_run,
  input logic [DIV_W-1:0]     div_cnt
);

  for (genvar g = 0; g < CCG_N_GRP; g++) begin : g_grp
    AST_LOW_WHILE_SRC_LOW: assert property (@(posedge src_clk_i[g]) disable iff (!rst_ni)
      !cfg_test_i |-> !clk_o[g]); // R7
    AST_GATE_TRACKS_SYNC: assert property (@(posedge src_clk_i[g]) disable iff (!rst_ni)
      gate_en[g] == run_sync[g]); // R7
  end

  AST_HIZ_NO_DRIVE: assert property (@(posedge ext_tck_i) disable iff (!rst_ni)
    cfg_hiz_i |-> (clk_oe_o == '0)); // R8

  AST_DIV_RESTART: assert property (@(posedge ext_tck_i) disable iff (!rst_ni)
    !div_run |=> (div_cnt == '0)); // R10

  AST_DIV_LOW_BEFORE_RUN: assert property (@(posedge ext_tck_i) disable iff (!rst_ni)
    (cfg_test_i && !cfg_hiz_i && !div_run && $past(!div_run)) |-> (clk_o[GRP_CPU] == 1'b0)); // R10

endmodule

bind ccg_clk_ctrl ccg_clk_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .rst_ni     (rst_ni),
  .src_clk_i  (src_clk_i),
  .ext_tck_i  (ext_tck_i),
  .cfg_hiz_i  (cfg_hiz_i),
  .cfg_test_i (cfg_test_i),
  .clk_o      (clk_o),
  .clk_oe_o   (clk_oe_o),
  .gate_en    (gate_en),
  .run_sync   (run_sync),
  .div_run    (div_run),
  .div_cnt    (div_cnt)
);

// File: tb/test_ccg_clk_ctrl.sv
`timescale 1ns/1ps
module test_ccg_clk_ctrl;
  import ccg_pkg::*;

  localparam int NG = CCG_N_GRP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  wire  [NG-1:0] src_clk;
  logic          lock = 1'b1;
  logic          cpu_n = 1'b1;
  logic          pci_n = 1'b1;
  logic          slp_n = 1'b1;
  logic          hiz = 1'b0;
  logic          tst = 1'b0;
  wire  [NG-1:0] clk_out;
  wire  [NG-1:0] oe;
  wire           osc_off;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  int rise_cnt  [NG];
  int short_cnt [NG];
  int win_cnt   [NG];

  always #2 clk = ~clk;  // 250 MHz test clock

  function automatic real half_ns(input int g);
    case (g)
      0: return 7.0;   1: return 13.0;  2: return 10.0;  3: return 8.0;
      4: return 6.0;   5: return 15.0;  6: return 17.0;  default: return 5.0;
    endcase
  endfunction

  // Divide ratio in test mode, restated from R9
  function automatic int test_div(input int g);
    if (g == 0 || g == 1) return 1;
    if (g == 5 || g == 6) return 4;
    return 2;
  endfunction

  for (genvar g = 0; g < NG; g++) begin : g_src
    logic c = 1'b0;
    real  t_rise = 0.0;
    initial forever #(half_ns(g)) c = ~c;
    assign src_clk[g] = c;
    initial begin rise_cnt[g] = 0; short_cnt[g] = 0; end
    always @(posedge clk_out[g]) begin
      rise_cnt[g] = rise_cnt[g] + 1;
      t_rise = $realtime;
    end
    always @(negedge clk_out[g]) begin
      if (($realtime - t_rise) < half_ns(g) - 0.1) short_cnt[g] = short_cnt[g] + 1;
    end
  end

  ccg_clk_ctrl i_ccg_clk_ctrl (
    .rst_ni        (rst_n),
    .src_clk_i     (src_clk),
    .ext_tck_i     (clk),
    .pm_pin_lock_i (lock),
    .cpu_halt_ni   (cpu_n),
    .pci_halt_ni   (pci_n),
    .sleep_ni      (slp_n),
    .cfg_hiz_i     (hiz),
    .cfg_test_i    (tst),
    .clk_o         (clk_out),
    .clk_oe_o      (oe),
    .osc_pll_off_o (osc_off)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure(input int win);
    int start [NG];
    for (int g = 0; g < NG; g++) start[g] = rise_cnt[g];
    #(win);
    for (int g = 0; g < NG; g++) win_cnt[g] = rise_cnt[g] - start[g];
  endtask

  // Settle, then check each group: running with nominal edge count, or stopped and low
  task automatic check_groups(input string req, input logic [NG-1:0] exp_run);
    int win = 600;
    #300;
    measure(win);
    for (int g = 0; g < NG; g++) begin
      if (exp_run[g]) begin
        int e = int'(real'(win) / (2.0 * half_ns(g)));
        chk(win_cnt[g] >= e - 1 && win_cnt[g] <= e + 1, req, $sformatf("running edges bit %0d", g), win_cnt[g], e);
      end else begin
        chk(win_cnt[g] == 0 && clk_out[g] == 1'b0, req, $sformatf("stopped edges bit %0d", g), win_cnt[g], 0);
      end
    end
  endtask

  task automatic pins(input logic l, input logic c, input logic p, input logic s);
    @(negedge clk);
    lock = l; cpu_n = c; pci_n = p; slp_n = s;
  endtask

  task automatic t_reset;
    #200;
    @(negedge clk);
    chk(clk_out == '0, "R1", "outputs in reset", int'(clk_out), 0);
    chk(oe == '1, "R8", "enables with hiz low", int'(oe), 255);
    rst_n = 1'b1;
  endtask

  task automatic t_lock;
    pins(1'b1, 1'b0, 1'b0, 1'b0);
    check_groups("R2", 8'hFF);
    chk(osc_off == 1'b0, "R2", "osc off with lock", int'(osc_off), 0);
  endtask

  task automatic t_sleep;
    pins(1'b0, 1'b1, 1'b1, 1'b0);
    check_groups("R3", 8'h00);
    chk(osc_off == 1'b1, "R3", "osc off in sleep", int'(osc_off), 1);
  endtask

  task automatic t_cpu_halt;
    pins(1'b0, 1'b0, 1'b1, 1'b1);
    check_groups("R4", 8'hEF);
    chk(osc_off == 1'b0, "R4", "osc off on cpu halt", int'(osc_off), 0);
  endtask

  task automatic t_pci_halt;
    pins(1'b0, 1'b1, 1'b0, 1'b1);
    check_groups("R5", 8'hDF);
  endtask

  task automatic t_both_halt;
    pins(1'b0, 1'b0, 1'b0, 1'b1);
    check_groups("R6", 8'hCF);
  endtask

  task automatic t_glitch;
    int s0 [NG];
    int r0;
    pins(1'b0, 1'b1, 1'b1, 1'b1);
    #200;
    for (int g = 0; g < NG; g++) s0[g] = short_cnt[g];
    for (int i = 0; i < 10; i++) begin
      #(3 + i * 7) cpu_n = 1'b0;
      #(11 + i * 5) cpu_n = 1'b1;
    end
    // R7: sleep pulses at odd offsets too
    for (int i = 0; i < 4; i++) begin
      #(5 + i * 9) slp_n = 1'b0;
      #(23 + i * 4) slp_n = 1'b1;
    end
    #200;
    for (int g = 0; g < NG; g++)
      chk(short_cnt[g] == s0[g], "R7", $sformatf("short pulses bit %0d", g), short_cnt[g] - s0[g], 0);
    // R7 restart latency: within three CPU periods of release
    cpu_n = 1'b0;
    #100;
    r0 = rise_cnt[GRP_CPU];
    #1 cpu_n = 1'b1;
    #37;
    chk(rise_cnt[GRP_CPU] > r0, "R7", "cpu restart edges", rise_cnt[GRP_CPU] - r0, 1);
  endtask

  task automatic t_hiz;
    @(negedge clk); hiz = 1'b1;
    @(negedge clk);
    chk(oe == '0, "R8", "enables with hiz", int'(oe), 0);
    tst = 1'b1;
    repeat (5) @(negedge clk);
    chk(oe == '0, "R8", "enables with hiz and test", int'(oe), 0);
    hiz = 1'b0; tst = 1'b0;
    @(negedge clk);
    chk(oe == '1, "R8", "enables after hiz", int'(oe), 255);
  endtask

  task automatic t_test_ratio;
    int win = 400;
    pins(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); tst = 1'b1;
    repeat (20) @(negedge clk);
    measure(win);
    for (int g = 0; g < NG; g++) begin
      int e = win / (4 * test_div(g));
      chk(win_cnt[g] >= e - 1 && win_cnt[g] <= e + 1, "R9", $sformatf("test edges bit %0d", g), win_cnt[g], e);
    end
    @(negedge clk); tst = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_div_phase;
    logic exp_h [1:5];
    logic exp_q [1:5];
    exp_h[1] = 0; exp_h[2] = 0; exp_h[3] = 1; exp_h[4] = 0; exp_h[5] = 1;
    exp_q[1] = 0; exp_q[2] = 0; exp_q[3] = 0; exp_q[4] = 1; exp_q[5] = 1;
    for (int rep = 0; rep < 2; rep++) begin
      @(negedge clk); tst = 1'b1;
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        chk(clk_out[GRP_CPU] == exp_h[k], "R10", $sformatf("half tap after edge %0d", k), int'(clk_out[GRP_CPU]), int'(exp_h[k]));
        chk(clk_out[GRP_PCI] == exp_q[k], "R10", $sformatf("quarter tap after edge %0d", k), int'(clk_out[GRP_PCI]), int'(exp_q[k]));
      end
      repeat (7) @(negedge clk);
      tst = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lock();
    t_sleep();
    t_cpu_halt();
    t_pci_halt();
    t_both_halt();
    t_glitch();
    t_hiz();
    t_test_ratio();
    t_div_phase();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule